// File: doc/BRIEF.md
# GPIO Bank with Event Interrupts

This block is one bank of thirty-two general-purpose pins behind a small word-addressed register bus. Every pin can be switched between driving and sensing. Driven pins take their level from an output latch. Sensed pins pass through a two-stage synchronizer and an optional debounce filter, and the filtered level can be read back over the bus. A system with more pins places several banks side by side. The upper bits of a global pin number (the number divided by 32) pick the bank, and the low five bits pick the bit inside it.

Four detectors watch each filtered pin: rising edge, falling edge, high level and low level. Software arms any mix of them per pin. A detected condition sets a sticky status bit, whether or not that pin's interrupt is enabled. The single interrupt output is raised while any status bit is pending on a pin whose enable bit is set. The output latch and the enable mask each have a set alias and a clear alias, so one pin can be changed without read-modify-write. Status is cleared by writing ones. A self-clearing soft-reset request returns the whole bank to its power-on state.

Reads are registered: a read strobe returns data, with `rvalid` high, one cycle later. Writes take effect on the clock edge that samples them.

Top module: `gpio_bank`

## Requirements
- R1: A read of word 0x00 returns the revision: major version in bits 7:4 (value 2) and minor version in bits 3:0 (value 1), so 0x00000021. All other bits read 0.
- R2: After reset, direction (word 0x02) reads 0xFFFFFFFF. Output latch (0x03), status (0x07) and interrupt enable (0x08) read 0. `pin_oe` and `irq` are low.
- R3: In the direction register a 1 makes the pin an input and a 0 makes it an output. `pin_oe` is the bitwise inverse of the direction register.
- R4: Writing a mask to word 0x04 sets the masked bits of the output latch, and writing to 0x05 clears them. Bits written as 0 keep their value. Word 0x03 is the latch itself, writable and readable, and it drives `pin_out`.
- R5: Word 0x06 returns the filtered pin levels. With debounce off, a change at `pin_in` is visible to a read issued 4 cycles later.
- R6: Per-pin arm registers select rising-edge (0x0B) and falling-edge (0x0C) detection. A detected edge on an armed pin sets its bit in the status register (0x07). Unarmed pins never set status.
- R7: Per-pin arm registers select high-level (0x0D) and low-level (0x0E) detection. While an armed level persists, its status bit sets again on the cycle after it is cleared.
- R8: The status register is write-one-to-clear. Bits written as 0 are left pending.
- R9: The interrupt enable mask reads at 0x08 and is set through 0x09 and cleared through 0x0A with write-ones semantics. `irq` is high exactly when some status bit and its enable bit are both 1. Status still records events on disabled pins.
- R10: Debounce is enabled per pin through 0x0F. The shared debounce time at 0x10 keeps only the low 8 bits of a write. A debounced pin takes a new level only after it has been stable for (time + 1) ticks of a divided clock, so shorter pulses are rejected.
- R11: Writing 1 to bit 1 of word 0x01 starts a soft reset. Bit 1 reads 1 while it runs, and the reset ends on its own after 4 cycles with every register back at its R2 value and the debounce time at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch to pad drivers |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Bank interrupt request |

## Verification
The bound checker checks on every cycle the properties below:
- `irq` never rises with an empty enable mask.
- No status bit rises on a pin with no detector armed.
- The set and clear aliases force the addressed latch bits.
- A status write leaves the written bits clear.
- A soft reset never lasts beyond four cycles and always lands on the reset values.

The scenarios alone show the rest:
- the exact latency from pin to read-back;
- which detector kinds fire for which transitions;
- a held level re-asserting its bit right after a clear;
- the debounce filter rejecting a short pulse while accepting a long one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS      = 32;
    localparam int AW        = 5;
    localparam int DBW       = 8;
    localparam logic [3:0] REV_MAJOR = 4'd2;
    localparam logic [3:0] REV_MINOR = 4'd1;

    typedef enum logic [AW-1:0] {
        A_REV     = 5'h00,
        A_SYSCTL  = 5'h01,
        A_DIR     = 5'h02,
        A_OUT     = 5'h03,
        A_OUT_SET = 5'h04,
        A_OUT_CLR = 5'h05,
        A_PIN     = 5'h06,
        A_STAT    = 5'h07,
        A_IEN     = 5'h08,
        A_IEN_SET = 5'h09,
        A_IEN_CLR = 5'h0A,
        A_RISE    = 5'h0B,
        A_FALL    = 5'h0C,
        A_HIGH    = 5'h0D,
        A_LOW     = 5'h0E,
        A_DBEN    = 5'h0F,
        A_DBTIME  = 5'h10
    } reg_addr_e;

    typedef struct packed {
        logic [PINS-1:0] rise;
        logic [PINS-1:0] fall;
        logic [PINS-1:0] high;
        logic [PINS-1:0] low;
    } arm_t;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] dout;
        logic [PINS-1:0] ien;
        logic [PINS-1:0] db_en;
        logic [DBW-1:0]  db_time;
        arm_t            arm;
    } cfg_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c         = '0;
        c.dir     = '1;
        return c;
    endfunction

    function automatic logic [PINS-1:0] any_armed(input arm_t a);
        return a.rise | a.fall | a.high | a.low;
    endfunction

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int SRST_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] ev_edge,
    input  logic [PINS-1:0] ev_lvl,
    output cfg_t            cfg,
    output logic [PINS-1:0] stat,
    output logic            busy
);
    localparam int CW = $clog2(SRST_CYC + 1);

    logic [CW-1:0]   srst_cnt;
    logic [PINS-1:0] clr_mask;
    logic            hit_stat;

    assign busy     = (srst_cnt != '0);
    assign hit_stat = wr_en && (addr == A_STAT);
    assign clr_mask = hit_stat ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_cnt <= '0;
        end else if (busy) begin
            srst_cnt <= srst_cnt - 1'b1;
        end else if (wr_en && addr == A_SYSCTL && wdata[1]) begin
            srst_cnt <= CW'(SRST_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            cfg  <= cfg_default();
            stat <= '0;
        end else begin
            stat <= (stat & ~clr_mask) | ev_edge | (ev_lvl & ~clr_mask);
            if (wr_en) begin
                case (addr)
                    A_DIR:     cfg.dir      <= wdata;
                    A_OUT:     cfg.dout     <= wdata;
                    A_OUT_SET: cfg.dout     <= cfg.dout | wdata;
                    A_OUT_CLR: cfg.dout     <= cfg.dout & ~wdata;
                    A_IEN:     cfg.ien      <= wdata;
                    A_IEN_SET: cfg.ien      <= cfg.ien | wdata;
                    A_IEN_CLR: cfg.ien      <= cfg.ien & ~wdata;
                    A_RISE:    cfg.arm.rise <= wdata;
                    A_FALL:    cfg.arm.fall <= wdata;
                    A_HIGH:    cfg.arm.high <= wdata;
                    A_LOW:     cfg.arm.low  <= wdata;
                    A_DBEN:    cfg.db_en    <= wdata;
                    A_DBTIME:  cfg.db_time  <= wdata[DBW-1:0];
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_bank_filter.sv
module gpio_bank_filter
    import gpio_bank_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_async,
    input  logic [PINS-1:0] db_en,
    input  logic [DBW-1:0]  db_time,
    output logic [PINS-1:0] level
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [DW-1:0]   div_cnt;
    logic            tick;
    logic [PINS-1:0] sync1;
    logic [PINS-1:0] sync2;

    assign tick = (div_cnt == DW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) div_cnt <= '0;
        else             div_cnt <= div_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= pin_async;
            sync2 <= sync1;
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic [DBW-1:0] stab_cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                level[p] <= 1'b0;
                stab_cnt <= '0;
            end else if (!db_en[p]) begin
                level[p] <= sync2[p];
                stab_cnt <= '0;
            end else if (sync2[p] == level[p]) begin
                stab_cnt <= '0;
            end else if (tick) begin
                if (stab_cnt == db_time) begin
                    level[p] <= sync2[p];
                    stab_cnt <= '0;
                end else begin
                    stab_cnt <= stab_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] level,
    input  arm_t            arm,
    output logic [PINS-1:0] ev_edge,
    output logic [PINS-1:0] ev_lvl
);
    logic [PINS-1:0] prev;
    logic [PINS-1:0] went_up;
    logic [PINS-1:0] went_down;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= level;
    end

    assign went_up   = level & ~prev;
    assign went_down = ~level & prev;
    assign ev_edge   = (went_up & arm.rise) | (went_down & arm.fall);
    assign ev_lvl    = (level & arm.high) | (~level & arm.low);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int SRST_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] rdata,
    output logic            rvalid,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            irq
);
    cfg_t            cfg;
    logic [PINS-1:0] stat_q;
    logic            busy;
    logic            core_rst;
    logic [PINS-1:0] level;
    logic [PINS-1:0] ev_edge;
    logic [PINS-1:0] ev_lvl;
    logic [PINS-1:0] rd_mux;
    logic [PINS-1:0] ien_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] arm_any;

    assign core_rst = rst | busy;
    assign ien_q    = cfg.ien;
    assign out_q    = cfg.dout;
    assign dir_q    = cfg.dir;
    assign arm_any  = any_armed(cfg.arm);

    gpio_bank_regs #(.SRST_CYC(SRST_CYC)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .ev_edge (ev_edge),
        .ev_lvl  (ev_lvl),
        .cfg     (cfg),
        .stat    (stat_q),
        .busy    (busy)
    );

    gpio_bank_filter #(.TICK_DIV(TICK_DIV)) filt_i (
        .clk       (clk),
        .rst       (core_rst),
        .pin_async (pin_in),
        .db_en     (cfg.db_en),
        .db_time   (cfg.db_time),
        .level     (level)
    );

    gpio_bank_detect det_i (
        .clk     (clk),
        .rst     (core_rst),
        .level   (level),
        .arm     (cfg.arm),
        .ev_edge (ev_edge),
        .ev_lvl  (ev_lvl)
    );

    always_comb begin
        rd_mux = '0;
        case (addr)
            A_REV:    rd_mux = {{(PINS-8){1'b0}}, REV_MAJOR, REV_MINOR};
            A_SYSCTL: rd_mux = {{(PINS-2){1'b0}}, busy, 1'b0};
            A_DIR:    rd_mux = cfg.dir;
            A_OUT:    rd_mux = cfg.dout;
            A_PIN:    rd_mux = level;
            A_STAT:   rd_mux = stat_q;
            A_IEN:    rd_mux = cfg.ien;
            A_RISE:   rd_mux = cfg.arm.rise;
            A_FALL:   rd_mux = cfg.arm.fall;
            A_HIGH:   rd_mux = cfg.arm.high;
            A_LOW:    rd_mux = cfg.arm.low;
            A_DBEN:   rd_mux = cfg.db_en;
            A_DBTIME: rd_mux = {{(PINS-DBW){1'b0}}, cfg.db_time};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end

    assign pin_out = cfg.dout;
    assign pin_oe  = ~cfg.dir;
    assign irq     = |(stat_q & cfg.ien);

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [PINS-1:0] wdata,
    input logic            irq,
    input logic [PINS-1:0] stat_q,
    input logic [PINS-1:0] ien_q,
    input logic [PINS-1:0] out_q,
    input logic [PINS-1:0] dir_q,
    input logic [PINS-1:0] arm_any,
    input logic            busy
);
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ien_q != '0));

    p_stat_only_armed_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(arm_any)) == '0));

    p_out_set_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_OUT_SET && !busy) |=> ((out_q & $past(wdata)) == $past(wdata)));

    p_out_clr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_OUT_CLR && !busy) |=> ((out_q & $past(wdata)) == '0));

    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_STAT && !busy && arm_any == '0) |=> ((stat_q & $past(wdata)) == '0));

    p_srst_len_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !($past(busy, 1) && $past(busy, 2) && $past(busy, 3) && $past(busy, 4)));

    p_srst_vals_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (dir_q == '1 && out_q == '0 && ien_q == '0 && stat_q == '0));

endmodule

bind gpio_bank gpio_bank_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .stat_q  (stat_q),
    .ien_q   (ien_q),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .arm_any (arm_any),
    .busy    (busy)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    import gpio_bank_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [PINS-1:0] wdata = '0;
    logic [PINS-1:0] rdata;
    logic            rvalid;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out;
    logic [PINS-1:0] pin_oe;
    logic            irq;

    always #4 clk = ~clk;

    gpio_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int n_cmp  = 0;
    int n_bad  = 0;
    bit done   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // driver: all tasks start and end at a falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rvalid) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL unexpected read data: actual %08h expected none", rdata);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                chk(it.tag, rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : stim
        idle(4);
        rst = 1'b0;
        idle(1);

        // R2 reset state
        chk("R2 pin_oe", pin_oe, 32'h0);
        chk("R2 irq", {31'b0, irq}, 32'h0);
        rd(A_DIR,  32'hFFFF_FFFF, "R2 dir");
        rd(A_OUT,  32'h0, "R2 out");
        rd(A_STAT, 32'h0, "R2 stat");
        rd(A_IEN,  32'h0, "R2 ien");

        // R1 revision
        rd(A_REV, 32'h0000_0021, "R1 revision");

        // R3 direction
        wr(A_DIR, 32'hFFFF_000F);
        rd(A_DIR, 32'hFFFF_000F, "R3 dir readback");
        chk("R3 pin_oe", pin_oe, 32'h0000_FFF0);

        // R4 set / clear aliases
        wr(A_OUT_SET, 32'h0000_00A5);
        rd(A_OUT, 32'h0000_00A5, "R4 set");
        wr(A_OUT_CLR, 32'h0000_0005);
        rd(A_OUT, 32'h0000_00A0, "R4 clear");
        wr(A_OUT_SET, 32'h0);
        rd(A_OUT, 32'h0000_00A0, "R4 zero mask no effect");
        wr(A_OUT, 32'h1234_5678);
        chk("R4 pin_out", pin_out, 32'h1234_5678);

        // R5 input readback
        pin_in = 32'hDEAD_BEEF;
        idle(4);
        rd(A_PIN, 32'hDEAD_BEEF, "R5 pin readback");
        pin_in = 32'h0;
        idle(6);
        rd(A_PIN, 32'h0, "R5 pin low");

        // R6 edge detection
        wr(A_RISE, 32'h0000_0003);
        wr(A_FALL, 32'h0000_0002);
        wr(A_STAT, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0103;
        idle(6);
        rd(A_STAT, 32'h0000_0003, "R6 rising pins 0,1 only");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R8 all ones clears");
        pin_in = 32'h0;
        idle(6);
        rd(A_STAT, 32'h0000_0002, "R6 falling pin 1 only");

        // R8 write zero keeps pending
        wr(A_STAT, 32'h0);
        rd(A_STAT, 32'h0000_0002, "R8 zero write keeps");

        // R9 disabled pin still records, irq gating
        chk("R9 irq low while disabled", {31'b0, irq}, 32'h0);
        wr(A_IEN_SET, 32'h0000_0002);
        chk("R9 irq high when enabled", {31'b0, irq}, 32'h1);
        rd(A_IEN, 32'h0000_0002, "R9 ien set alias");
        wr(A_IEN_SET, 32'h0000_0010);
        wr(A_IEN_CLR, 32'h0000_0002);
        rd(A_IEN, 32'h0000_0010, "R9 ien clear alias");
        chk("R9 irq low after disable", {31'b0, irq}, 32'h0);
        wr(A_STAT, 32'h0000_0002);
        wr(A_RISE, 32'h0);
        wr(A_FALL, 32'h0);

        // R7 level detection, re-set after clear
        wr(A_HIGH, 32'h0000_0010);
        pin_in = 32'h0000_0010;
        idle(6);
        rd(A_STAT, 32'h0000_0010, "R7 high level");
        chk("R9 irq from level", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h0000_0010);
        rd(A_STAT, 32'h0, "R7 cleared for one cycle");
        rd(A_STAT, 32'h0000_0010, "R7 level re-sets");
        wr(A_HIGH, 32'h0);
        pin_in = 32'h0;
        idle(6);
        wr(A_LOW, 32'h0000_0040);
        idle(3);
        rd(A_STAT, 32'h0000_0050, "R7 low level adds pin 6");
        wr(A_LOW, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 32'h0, "R8 clear after disarm");

        // R10 debounce
        wr(A_DBTIME, 32'h0000_0102);
        rd(A_DBTIME, 32'h0000_0002, "R10 time keeps low byte");
        wr(A_DBEN, 32'h0000_0020);
        pin_in = 32'h0000_0020;
        idle(5);
        pin_in = 32'h0;
        idle(20);
        rd(A_PIN, 32'h0, "R10 short pulse rejected");
        pin_in = 32'h0000_0020;
        idle(6);
        rd(A_PIN, 32'h0, "R10 not yet accepted");
        idle(30);
        rd(A_PIN, 32'h0000_0020, "R10 stable level accepted");

        // R11 soft reset
        wr(A_OUT, 32'h0000_00FF);
        wr(A_DIR, 32'h0);
        wr(A_IEN, 32'h0000_000F);
        wr(A_SYSCTL, 32'h0000_0002);
        rd(A_SYSCTL, 32'h0000_0002, "R11 busy while running");
        idle(6);
        rd(A_SYSCTL, 32'h0, "R11 self clears");
        rd(A_DIR, 32'hFFFF_FFFF, "R11 dir restored");
        rd(A_OUT, 32'h0, "R11 out restored");
        rd(A_IEN, 32'h0, "R11 ien restored");
        rd(A_DBTIME, 32'h0, "R11 debounce time restored");
        chk("R11 pin_oe", pin_oe, 32'h0);

        idle(3);
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1;
        finish_run();
    end

endmodule